// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register

This block is an 8-bit interrupt flag register that software can read and write. It gathers event indications from several on-chip peripherals: an analog-to-digital converter, a serial receiver and transmitter, a capture/compare/PWM unit, a period timer and an overflow timer. It presents them as one byte of flags. There are two kinds of flag. Sticky flags latch a single-cycle event and hold it until software writes a zero to that bit. Status flags are read-only and follow the live level of a serial buffer.

The flag for the capture/compare unit takes its event from a source chosen by the unit's mode input. Each flag has a matching enable bit, and there is also a global enable. The interrupt request output is high whenever any enabled flag is set and the global enable is high. Flags are set whatever the enables hold, so software can poll the register with interrupts masked.

Top module: `irqf_register`

## Requirements
- R1: Bit positions 7 and 3 always read as zero, and writes to them have no effect.
- R2: Each flag sets on its condition whatever the values of `bit_en` and `glb_en`.
- R3: After reset, every sticky flag (bits 6, 2, 1, 0) reads zero.
- R4: Bit 6 sets in the cycle after `adc_done` is sampled high and holds until a register write carries a zero in bit 6.
- R5: Bit 5 equals `rx_buf_full` and bit 4 equals `tx_buf_empty` in the same cycle, with no register in between. Writes to these bits have no effect.
- R6: Bit 2 takes its set source from `ccu_mode`. Encoding 00 selects `cap_evt` and 01 selects `cmp_evt`. Encodings 10 and 11 (PWM) select no source, so hardware never sets the bit in those modes.
- R7: Bit 1 sets on `per_match` and bit 0 sets on `t1_ovf`. Once set, each holds until a write carries a zero in that bit.
- R8: If a hardware set and a write of zero reach the same sticky bit in the same cycle, the bit ends up set.
- R9: A write with a one in a sticky bit position sets that bit.
- R10: `irq` equals `glb_en` AND the OR, over all eight positions, of (read-data bit AND `bit_en` bit). It is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (combinational view of flags) |
| adc_done | input | 1 | Conversion-complete pulse |
| rx_buf_full | input | 1 | Serial receive buffer holds data (level) |
| tx_buf_empty | input | 1 | Serial transmit buffer is empty (level) |
| cap_evt | input | 1 | Capture event pulse |
| cmp_evt | input | 1 | Compare match pulse |
| ccu_mode | input | 2 | Unit mode: 00 capture, 01 compare, 1x PWM |
| per_match | input | 1 | Period timer match pulse |
| t1_ovf | input | 1 | Overflow timer pulse |
| bit_en | input | 8 | Per-flag interrupt enables |
| glb_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes every byte value and checks that only sticky positions take the written value and that unimplemented and status positions ignore the write. A design that stored a written status bit, or let bit 7 or 3 read back, fails there. For every combination of flags, enables and global enable it compares `irq` against an expected value computed arithmetically, which catches a missing global gate or a wrong enable pairing. It drives a set pulse together with a write of zero on each sticky bit; a design that gave the clear priority would lose the event. It also sweeps all four `ccu_mode` encodings against both event inputs, so a design that took capture events in compare mode, or set the flag in PWM mode, would show a flag where none is expected.

// File: rtl/irqf_pkg.sv
// Package: bit positions, masks and the mode encoding shared by the flag register.
// Assumes an 8-bit register. Positions are fixed because software decodes them.
package irqf_pkg;
    localparam int REG_W    = 8;
    localparam int POS_CONV = 6;
    localparam int POS_RX   = 5;
    localparam int POS_TX   = 4;
    localparam int POS_CCU  = 2;
    localparam int POS_PER  = 1;
    localparam int POS_OVF  = 0;

    localparam logic [REG_W-1:0] STICKY_MASK = 8'b0100_0111;
    localparam logic [REG_W-1:0] STATUS_MASK = 8'b0011_0000;

    typedef enum logic [1:0] {
        CCU_CAPTURE = 2'b00,
        CCU_COMPARE = 2'b01,
        CCU_PWM     = 2'b10,
        CCU_PWM_ALT = 2'b11
    } ccu_mode_e;
endpackage

// File: rtl/irqf_sticky_bank.sv
// Sticky flag bank. Each bit selected by MASK latches a set pulse and keeps it.
// A register write loads the written value, and a hardware set in the same cycle
// overrides a written zero. Bits outside MASK are tied to zero.
// Assumes set_vec pulses are synchronous to clk.
module irqf_sticky_bank #(
    parameter int                 W    = 8,
    parameter logic [W-1:0]       MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    logic unused_bits;

    // Fold the bits this bank never reads into one ignored signal.
    assign unused_bits = ^{set_vec & ~MASK, wr_data & ~MASK};

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_sticky
            // Latch set events; a write loads the written bit; a set beats a clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[i] <= 1'b0;
                else if (set_vec[i])
                    q[i] <= 1'b1;
                else if (wr_en)
                    q[i] <= wr_data[i];
            end
        end else begin : g_tied
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irqf_ccu_src.sv
// Set-source selector for the capture/compare flag. It forwards the capture or
// compare event according to the unit mode, and forwards nothing in PWM mode.
// Assumes the events are single-cycle pulses.
module irqf_ccu_src
    import irqf_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       cap_evt,
    input  logic       cmp_evt,
    output logic       hit
);
    ccu_mode_e mode_e;

    // Map the raw mode bits onto the named encoding.
    assign mode_e = ccu_mode_e'(mode);

    // Choose the event source that belongs to the current mode.
    always_comb begin
        unique case (mode_e)
            CCU_CAPTURE: hit = cap_evt;
            CCU_COMPARE: hit = cmp_evt;
            default:     hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/irqf_req_combine.sv
// Request combiner. It ANDs each flag with its enable, ORs the result and
// gates it with the global enable. Purely combinational.
module irqf_req_combine #(
    parameter int W = 8
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] en,
    input  logic         glb_en,
    output logic         irq
);
    logic [W-1:0] live;

    // Keep only the flags whose enable is set, then gate globally.
    always_comb begin
        live = flags & en;
        irq  = glb_en & (|live);
    end
endmodule

// File: rtl/irqf_register.sv
// Peripheral interrupt flag register (top). It combines the sticky event flags,
// the live buffer status bits and the request combiner. Read data is
// combinational. Assumes all event inputs are synchronous to clk.
module irqf_register
    import irqf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             adc_done,
    input  logic             rx_buf_full,
    input  logic             tx_buf_empty,
    input  logic             cap_evt,
    input  logic             cmp_evt,
    input  logic [1:0]       ccu_mode,
    input  logic             per_match,
    input  logic             t1_ovf,
    input  logic [REG_W-1:0] bit_en,
    input  logic             glb_en,
    output logic             irq
);
    logic             ccu_hit;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] sticky_q;
    logic [REG_W-1:0] status_vec;

    irqf_ccu_src u_ccu (
        .mode    (ccu_mode),
        .cap_evt (cap_evt),
        .cmp_evt (cmp_evt),
        .hit     (ccu_hit)
    );

    // Place each hardware set event at its bit position.
    always_comb begin
        set_vec           = '0;
        set_vec[POS_CONV] = adc_done;
        set_vec[POS_CCU]  = ccu_hit;
        set_vec[POS_PER]  = per_match;
        set_vec[POS_OVF]  = t1_ovf;
    end

    irqf_sticky_bank #(
        .W    (REG_W),
        .MASK (STICKY_MASK)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .q       (sticky_q)
    );

    // Place the live buffer levels at their read-only positions.
    always_comb begin
        status_vec         = '0;
        status_vec[POS_RX] = rx_buf_full;
        status_vec[POS_TX] = tx_buf_empty;
    end

    // Read view: sticky flags merged with the masked live status.
    assign rd_data = sticky_q | (status_vec & STATUS_MASK);

    irqf_req_combine #(
        .W (REG_W)
    ) u_req (
        .flags  (rd_data),
        .en     (bit_en),
        .glb_en (glb_en),
        .irq    (irq)
    );
endmodule

// File: rtl/irqf_register_chk.sv
// Assertion checker for irqf_register, attached with bind. Port relations only.
module irqf_register_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       adc_done,
    input logic       rx_buf_full,
    input logic       tx_buf_empty,
    input logic [1:0] ccu_mode,
    input logic       per_match,
    input logic       t1_ovf,
    input logic       glb_en,
    input logic       irq
);
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] == 1'b0) && (rd_data[3] == 1'b0));                        // R1
    AST_CONV_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        adc_done |=> rd_data[6]);                                            // R4
    AST_RX_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[5] == rx_buf_full) && (rd_data[4] == tx_buf_empty));         // R5
    AST_PWM_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
        (ccu_mode[1] && !rd_data[2] && !(wr_en && wr_data[2])) |=> !rd_data[2]); // R6
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && !wr_en) |=> rd_data[0]);                              // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (per_match && wr_en && !wr_data[1]) |=> rd_data[1]);                 // R8
    AST_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[0] && !t1_ovf) |=> !rd_data[0]);                  // R7
    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !irq);                                                   // R10
endmodule

bind irqf_register irqf_register_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .adc_done     (adc_done),
    .rx_buf_full  (rx_buf_full),
    .tx_buf_empty (tx_buf_empty),
    .ccu_mode     (ccu_mode),
    .per_match    (per_match),
    .t1_ovf       (t1_ovf),
    .glb_en       (glb_en),
    .irq          (irq)
);

// File: tb/sim_irqf_register.sv
// Self-checking bench for irqf_register: sweeps writes, flag/enable patterns and modes.
module sim_irqf_register;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       adc_done = 1'b0;
    logic       rx_buf_full = 1'b0;
    logic       tx_buf_empty = 1'b0;
    logic       cap_evt = 1'b0;
    logic       cmp_evt = 1'b0;
    logic [1:0] ccu_mode = 2'b00;
    logic       per_match = 1'b0;
    logic       t1_ovf = 1'b0;
    logic [7:0] bit_en = '0;
    logic       glb_en = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irqf_register u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .adc_done(adc_done), .rx_buf_full(rx_buf_full), .tx_buf_empty(tx_buf_empty),
        .cap_evt(cap_evt), .cmp_evt(cmp_evt), .ccu_mode(ccu_mode), .per_match(per_match),
        .t1_ovf(t1_ovf), .bit_en(bit_en), .glb_en(glb_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Advance one clock; inputs change 1 ns after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        tick();
        wr_en = 1'b0;
        #1;
    endtask

    // Expected read-back after a plain write: sticky bits from data, status live.
    function automatic logic [7:0] exp_rd(input logic [7:0] w, input logic rx, input logic tx);
        return (w & 8'h47) | {2'b00, rx, tx, 4'b0000};
    endfunction

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R3: reset state
        chk("R3", rd_data, 8'h00);
        chk("R3", {7'd0, irq}, 8'h00);

        // R1 R5 R9: every write value with each status level combination
        for (int w = 0; w < 256; w++) begin
            rx_buf_full = w[0] ^ w[3];
            tx_buf_empty = w[7];
            reg_write(8'(w));
            chk("R1/R5/R9 write sweep", rd_data, exp_rd(8'(w), rx_buf_full, tx_buf_empty));
        end
        // R5: status follows levels in the same cycle, no clock
        reg_write(8'h00);
        for (int s = 0; s < 4; s++) begin
            rx_buf_full = s[0];
            tx_buf_empty = s[1];
            #1;
            chk("R5 live", rd_data, {2'b00, s[0], s[1], 4'b0000});
        end
        rx_buf_full = 1'b0;
        tx_buf_empty = 1'b0;

        // R2: events set flags with all enables off; irq stays low
        bit_en = '0;
        glb_en = 1'b0;
        adc_done = 1'b1; per_match = 1'b1; t1_ovf = 1'b1; cap_evt = 1'b1; ccu_mode = 2'b00;
        tick();
        adc_done = 1'b0; per_match = 1'b0; t1_ovf = 1'b0; cap_evt = 1'b0;
        #1;
        chk("R2 masked set", rd_data, 8'h47);
        chk("R2 no irq", {7'd0, irq}, 8'h00);

        // R4 R7: flags hold through idle cycles, clear only by written zero
        repeat (5) tick();
        chk("R4/R7 hold", rd_data, 8'h47);
        reg_write(8'h07);
        chk("R4 clear bit6", rd_data, 8'h07);
        reg_write(8'h04);
        chk("R7 clear bits 1 0", rd_data, 8'h04);
        reg_write(8'h00);
        adc_done = 1'b1;
        tick();
        adc_done = 1'b0;
        #1;
        chk("R4 set", rd_data, 8'h40);

        // R8: set beats a same-cycle written zero on each sticky bit
        for (int b = 0; b < 4; b++) begin
            reg_write(8'h00);
            wr_en = 1'b1;
            wr_data = 8'h00;
            ccu_mode = 2'b01;
            adc_done = (b == 0);
            cmp_evt = (b == 1);
            per_match = (b == 2);
            t1_ovf = (b == 3);
            tick();
            wr_en = 1'b0; adc_done = 1'b0; cmp_evt = 1'b0; per_match = 1'b0; t1_ovf = 1'b0;
            #1;
            chk("R8 set wins", rd_data, (b == 0) ? 8'h40 : (b == 1) ? 8'h04 : (b == 2) ? 8'h02 : 8'h01);
        end

        // R6: mode sweep against both event inputs
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 4; e++) begin
                reg_write(8'h00);
                ccu_mode = 2'(m);
                cap_evt = e[0];
                cmp_evt = e[1];
                tick();
                cap_evt = 1'b0;
                cmp_evt = 1'b0;
                #1;
                chk("R6 mode source", rd_data,
                    ((m == 0 && e[0]) || (m == 1 && e[1])) ? 8'h04 : 8'h00);
            end
        end

        // R10: all flag patterns x all enables x global enable
        for (int p = 0; p < 64; p++) begin
            logic [7:0] w;
            logic [7:0] er;
            w = {1'b0, p[3], 3'b000, p[2], p[1], p[0]};
            rx_buf_full = p[4];
            tx_buf_empty = p[5];
            reg_write(w);
            er = exp_rd(w, p[4], p[5]);
            chk("R10 pattern", rd_data, er);
            for (int en = 0; en < 256; en++) begin
                for (int g = 0; g < 2; g++) begin
                    bit_en = 8'(en);
                    glb_en = g[0];
                    #1;
                    chk("R10 irq", {7'd0, irq}, {7'd0, g[0] & (|(er & 8'(en)))});
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule